// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a ratio N = 8·M + A taken from a 14-bit parallel word. A divide-by-8/9 prescaler is modelled as synchronous logic on the input clock. A swallow count A and a main count M are both counted in prescaler output cycles. While the swallow count is still nonzero, the prescaler runs at modulus 9. After that it runs at modulus 8 until the main count is used up. At that point both counts reload from the bus, and a new division cycle starts.

Each division cycle produces one output pulse, eight input clocks wide, at its start. The bus has no load strobe: whatever word is present at a cycle boundary sets the next cycle. A word below the smallest legal ratio raises an error flag and is treated as the minimum ratio. Typical use is the feedback divider of a frequency synthesis loop, where the output pulse is compared against a reference.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the internal counts clear and `div_out` is low after that edge.
- R2: Successive rising edges of `div_out` are N input clocks apart. N = 8·M + A, where A = `ratio_word[2:0]` and M = `ratio_word[13:3]`.
- R3: Every pulse on `div_out` is exactly 8 input clocks wide. This is one modulus-8 prescaler period, whatever the values of A and M.
- R4: `ratio_err` is high in the same cycle whenever `ratio_word` is below 56, and low otherwise.
- R5: A word below 56 divides by exactly 56, which is M = 7 and A = 0.
- R6: A change on `ratio_word` takes effect with no strobe at the next cycle boundary, and the cycle in progress finishes with its old ratio.
- R7: `div_out` goes high at the first clock edge at which `rst_n` is sampled high after reset.
- R8: Within a cycle, the first A prescaler periods last 9 input clocks and the remaining M − A periods last 8. The swallow count never exceeds the main count, so M = 7 with A = 7 gives seven 9-clock periods and a ratio of 63.
- R9: The largest word, 16383 (M = 2047, A = 7), divides by 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_word | input | 14 | Ratio word; bits 2:0 are A, bits 13:3 are M |
| div_out | output | 1 | One 8-clock pulse per division cycle |
| ratio_err | output | 1 | High while the ratio word is below 56 |

## Verification
The assertions assume that `ratio_word` changes only away from the clock edge, and that any reset lasts at least one full clock. They also rely on the clamp, which keeps every loaded main count at 7 or more, so that a whole pulse always fits inside one cycle. The stimulus changes the word and the reset only on the falling clock edge. It includes words below 56, the boundary ratios 56, 63 and 16383, and a word changed in the middle of a cycle. This keeps every case inside the assumptions while still reaching the clamp and the all-nines case.

// File: rtl/divider_pkg.sv
// Package: shared sizing for the pulse-swallow divider.
// Assumes a 2^A_BITS / 2^A_BITS+1 prescaler and an M field above the A field.
package divider_pkg;
    localparam int A_BITS_DEF    = 3;
    localparam int M_BITS_DEF    = 11;
    localparam int MIN_RATIO_DEF = 56;
endpackage

// File: rtl/dm_prescaler.sv
// Dual-modulus prescaler: counts input clocks and pulses pre_tc at the end
// of each period, which is 2^A_BITS clocks, or one more while mod_hi is set.
// Assumes mod_hi changes only at a period boundary; restart holds the count at zero.
module dm_prescaler #(
    parameter int A_BITS = 3
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              mod_hi,
    output logic              pre_tc,
    output logic              low_half
);
    localparam int PW = A_BITS + 1;
    localparam logic [PW-1:0] LAST_LO = PW'((2 ** A_BITS) - 1);
    localparam logic [PW-1:0] LAST_HI = PW'(2 ** A_BITS);

    logic [PW-1:0] tick_q;

    // Terminal count depends on the current modulus.
    always_comb begin
        pre_tc = mod_hi ? (tick_q == LAST_HI) : (tick_q == LAST_LO);
    end

    // The first 2^A_BITS clocks of a period have the top bit clear.
    assign low_half = ~tick_q[PW-1];

    // Period counter: clears on reset or restart, wraps at terminal count.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart) tick_q <= '0;
        else if (pre_tc)       tick_q <= '0;
        else                   tick_q <= tick_q + PW'(1);
    end

    // R8: a modulus-9 period wraps after 9 clocks, a modulus-8 period after 8.
    a_r8_wrap_nine: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mod_hi && tick_q == LAST_HI && !restart) |=> (tick_q == '0));
    a_r8_no_nine_when_lo: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!mod_hi && tick_q == LAST_LO && !restart) |=> (tick_q == '0));
endmodule

// File: rtl/swallow_ctr.sv
// Swallow and main counters: both count prescaler periods. The swallow count
// holds the prescaler at the high modulus while nonzero; when the main count
// expires, both reload from the load inputs. Assumes load_m >= load_a and load_m > 0.
module swallow_ctr #(
    parameter int A_BITS   = 3,
    parameter int M_BITS   = 11,
    parameter int MIN_MAIN = 7
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              pre_tc,
    input  logic [M_BITS-1:0] load_m,
    input  logic [A_BITS-1:0] load_a,
    output logic              mod_hi,
    output logic              idle,
    output logic              first_per
);
    logic [M_BITS-1:0] main_q;
    logic [A_BITS-1:0] swal_q;
    logic              reload;

    assign idle   = (main_q == '0);
    assign mod_hi = (swal_q != '0);

    // Reload from idle after reset, or at the end of the last main period.
    always_comb begin
        reload = idle || (pre_tc && main_q == M_BITS'(1));
    end

    // Counter state: reload, or step both counts at each prescaler period end.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            main_q    <= '0;
            swal_q    <= '0;
            first_per <= 1'b0;
        end else if (reload) begin
            main_q    <= load_m;
            swal_q    <= load_a;
            first_per <= 1'b1;
        end else if (pre_tc) begin
            main_q    <= main_q - M_BITS'(1);
            swal_q    <= mod_hi ? swal_q - A_BITS'(1) : swal_q;
            first_per <= 1'b0;
        end
    end

    // R5: every cycle starts with a main count at or above the clamped floor.
    a_r5_load_floor: assert property (@(posedge clk_in) disable iff (!rst_n)
        (first_per && !$past(first_per)) |-> (main_q >= M_BITS'(MIN_MAIN)));
    // R8: the swallow count never exceeds the main count.
    a_r8_swallow_le_main: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && !idle) |-> (M_BITS'(swal_q) <= main_q));
endmodule

// File: rtl/pulse_swallow_divider.sv
// Top: splits the ratio word into the A (low) and M (high) fields after
// clamping to the minimum ratio, and drives a pulse during the first
// 2^A_BITS clocks of each division cycle. Assumes ratio_word is stable at clock edges.
module pulse_swallow_divider
    import divider_pkg::*;
#(
    parameter int A_BITS    = A_BITS_DEF,
    parameter int M_BITS    = M_BITS_DEF,
    parameter int MIN_RATIO = MIN_RATIO_DEF
) (
    input  logic                       clk_in,
    input  logic                       rst_n,
    input  logic [A_BITS+M_BITS-1:0]   ratio_word,
    output logic                       div_out,
    output logic                       ratio_err
);
    localparam int W        = A_BITS + M_BITS;
    localparam int MIN_MAIN = MIN_RATIO / (2 ** A_BITS);
    localparam logic [W-1:0] MIN_W = W'(MIN_RATIO);

    logic [W-1:0] eff_word;
    logic         pre_tc, low_half, mod_hi, idle, first_per;

    // Clamp short words to the minimum ratio and flag them.
    always_comb begin
        ratio_err = (ratio_word < MIN_W);
        eff_word  = ratio_err ? MIN_W : ratio_word;
    end

    dm_prescaler #(.A_BITS(A_BITS)) u_pre (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .restart (idle),
        .mod_hi  (mod_hi),
        .pre_tc  (pre_tc),
        .low_half(low_half)
    );

    swallow_ctr #(.A_BITS(A_BITS), .M_BITS(M_BITS), .MIN_MAIN(MIN_MAIN)) u_cnt (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .pre_tc   (pre_tc),
        .load_m   (eff_word[W-1:A_BITS]),
        .load_a   (eff_word[A_BITS-1:0]),
        .mod_hi   (mod_hi),
        .idle     (idle),
        .first_per(first_per)
    );

    // Pulse covers the first 2^A_BITS clocks of the first prescaler period.
    assign div_out = first_per & low_half;

    // R1: reset leaves the output low.
    a_r1_reset_low: assert property (@(posedge clk_in)
        !rst_n |=> !div_out);
    // R3: a pulse that ends was high for exactly 8 clocks.
    a_r3_width: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($fell(div_out) && $past(rst_n)) |-> ($past(div_out, 8) && !$past(div_out, 9)));
endmodule

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [13:0] ratio_word = 14'd56;
    logic        div_out, ratio_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int ph     = -1;
    int per    = 56;
    bit started = 0;

    pulse_swallow_divider uut (
        .clk_in(clk_in), .rst_n(rst_n), .ratio_word(ratio_word),
        .div_out(div_out), .ratio_err(ratio_err)
    );

    always #4 clk_in = ~clk_in;

    function automatic int eff(input logic [13:0] w);
        return (w < 14'd56) ? 56 : int'(w[13:3]) * 8 + int'(w[2:0]);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Behavioural reference: phase within the current division cycle.
    always @(posedge clk_in) begin
        started = 1;
        if (!rst_n) ph = -1;
        else if (ph < 0 || ph == per - 1) begin
            ph  = 0;
            per = eff(ratio_word);
        end else ph++;
    end

    // Per-clock comparison against the model (R2, R3, R4).
    always @(negedge clk_in) begin
        if (started) begin
            check(div_out === (ph >= 0 && ph < 8), "R2 per-clock output", int'(div_out), int'(ph >= 0 && ph < 8));
            check(ratio_err === (ratio_word < 14'd56), "R4 per-clock flag", int'(ratio_err), int'(ratio_word < 14'd56));
        end
    end

    // Watchdog.
    always @(posedge clk_in) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wait_rise();
        logic p;
        p = div_out;
        forever begin
            @(negedge clk_in);
            if (div_out && !p) break;
            p = div_out;
        end
    endtask

    // Set a word, wait for a cycle that uses it, measure period and width.
    task automatic measure(input logic [13:0] w, input int expn, input string req);
        int n, wd;
        logic p;
        ratio_word = w;
        wait_rise();
        n = 0; wd = 1; p = 1'b1;
        forever begin
            @(negedge clk_in);
            n++;
            if (div_out && !p) break;
            if (div_out) wd++;
            p = div_out;
        end
        check(n == expn, {req, " period"}, n, expn);
        check(wd == 8, "R3 pulse width", wd, 8);
    endtask

    initial begin
        int n;
        logic p;
        repeat (3) @(negedge clk_in);
        check(div_out == 1'b0, "R1 output during reset", int'(div_out), 0);
        rst_n = 1'b1;
        @(negedge clk_in);
        check(div_out == 1'b1, "R7 first pulse after reset", int'(div_out), 1);

        measure(14'd100, 100, "R2 ratio 100");
        measure(14'd1000, 1000, "R2 ratio 1000");
        measure(14'd56, 56, "R2 minimum ratio");
        measure(14'd63, 63, "R8 all-nines M=A=7");
        measure(14'd57, 57, "R8 one swallow");
        ratio_word = 14'd20;
        #1 check(ratio_err == 1'b1, "R4 short word flag", int'(ratio_err), 1);
        measure(14'd20, 56, "R5 clamp of 20");
        measure(14'd0, 56, "R5 clamp of 0");
        ratio_word = 14'd56;
        #1 check(ratio_err == 1'b0, "R4 flag clear at 56", int'(ratio_err), 0);
        measure(14'd16383, 16383, "R9 maximum ratio");

        // R6: change the word mid-cycle; current cycle keeps its old ratio.
        measure(14'd200, 200, "R2 ratio 200");
        repeat (50) @(negedge clk_in);
        ratio_word = 14'd80;
        wait_rise();
        n = 0; p = 1'b1;
        forever begin
            @(negedge clk_in);
            n++;
            if (div_out && !p) break;
            p = div_out;
        end
        check(n == 80, "R6 new word at next boundary", n, 80);

        // R1: reset in the middle of a pulse.
        wait_rise();
        repeat (2) @(negedge clk_in);
        rst_n = 1'b0;
        @(negedge clk_in);
        check(div_out == 1'b0, "R1 reset during pulse", int'(div_out), 0);
        @(negedge clk_in);
        check(div_out == 1'b0, "R1 held reset", int'(div_out), 0);
        rst_n = 1'b1;
        @(negedge clk_in);
        check(div_out == 1'b1, "R7 restart after reset", int'(div_out), 1);
        measure(14'd12345, 12345, "R2 ratio 12345");

        summary();
        $finish;
    end
endmodule